// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block runs one buffered-program operation on a parallel NOR flash through a simple synchronous bus. A client gives a target word address, a word count and a stream of data words. The block then waits for the device to report ready and opens a buffer-load sequence. It writes the count and the data words and confirms the operation. It then polls the status register until the device finishes or a cycle budget runs out, and ends with a single done pulse that carries a two-bit result.

Command writes and status reads use the command address. This is the target address with the low bits cleared, so that it points to the start of the write buffer that holds the target. Data words go to consecutive word addresses, starting at the target. After the confirm write the block waits an adaptive number of cycles before the first completion poll. It lowers this wait when the device was already done at the first poll, and raises it when completion took more than two polls. The programming-voltage control is a single enable output.

Top module: `bprog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `vpp_en`, `fl_we` and `fl_re` are all low.
- R2: Every command write and every status read uses the command address, which is `tgt_addr` with its low `BUF_LOG2` bits cleared. Data word i (counting from 0) is written to `tgt_addr + i`.
- R3: If `in_query` is high at `start`, the first bus write of the operation is 0x70 (enter status mode) at the command address.
- R4: Before any other write, the block reads status until bit 7 (ready) is 1. If the ready bit is still 0 when `READY_TO` cycles have passed since `start`, the operation ends with result 1 (timeout) and no write.
- R5: Once ready, the block writes 0xE8 (buffer setup) and reads status up to `BUF_POLLS` (20) times. A ready bit seen on the last allowed read is accepted.
- R6: If none of the `BUF_POLLS` reads shows the ready bit, the block writes 0x70, drops `vpp_en`, and ends with result 2 (not ready).
- R7: After the buffer is ready, the block writes the value `word_cnt-1`, then the `word_cnt` data words, then 0xD0 (confirm). `word_cnt` lies in 1..2^`BUF_LOG2`. `dat_take` is high in each cycle that consumes `dat_word`.
- R8: The first completion status read is issued W+1 cycles after the confirm write cycle. W is the adaptive wait, which is `WAIT_INIT` (4) after reset.
- R9: When completion is seen, W changes according to the number n of completion reads that showed not-ready: if n=0, W drops by 1 but never below 1; if n=1, W is unchanged; if n≥2, W rises by 1, saturating at its maximum. A timeout or a not-ready ending leaves W unchanged.
- R10: If completion is not seen within `READY_TO/2` cycles after the wait, the result is 1 (timeout), and no clear command is written.
- R11: If status bit 1 (lock) is set when completion is seen, the block writes 0x50 (clear status) and then 0x70, and the result is 3 (protected). Otherwise the result is 0 (success).
- R12: `vpp_en` is high from the 0xE8 write cycle through the last completion poll, including the confirm write. It is low while the block is idle or `done` is high.
- R13: Each `start` taken while idle yields exactly one `done` pulse, one cycle long, with `result` valid in that cycle.
- R14: `fl_rdata` is sampled in the cycle after `fl_re`. `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when idle) |
| tgt_addr | input | AW | Target word address |
| word_cnt | input | BUF_LOG2+1 | Number of words, 1..2^BUF_LOG2 |
| in_query | input | 1 | Device is in query mode, so status mode must be entered first |
| dat_word | input | DW | Next data word from the source |
| dat_take | output | 1 | Current data word is consumed this cycle |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_rdata | input | DW | Flash status data, valid in the cycle after fl_re |
| vpp_en | output | 1 | Programming voltage enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 not ready, 3 protected |

## Verification
The assertions check on every cycle the properties that hold at the bus: reads and writes never overlap, the block is quiet while idle, and each done pulse lasts one cycle with the voltage enable low. They also check that the setup command only appears while the voltage enable is high, and that a clear-status command is always followed by the status-mode command. The order of a whole operation can only be shown by the directed scenarios, which drive a status model with scripted busy counts. These cover the command and data order, the address alignment, the exact poll limits, the timeout and lock endings, and how the adaptive wait changes from one operation to the next, measured as the gap between the confirm write and the first poll.

// File: rtl/bprog_pkg.sv
package bprog_pkg;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_TIMEOUT   = 2'd1,
        RES_NOT_READY = 2'd2,
        RES_LOCKED    = 2'd3
    } bp_result_e;

    typedef enum logic [4:0] {
        S_IDLE, S_QRY, S_PRE_RD, S_PRE_EV, S_SETUP, S_BR_RD, S_BR_EV,
        S_NR_EXIT, S_COUNT, S_DATA, S_CONFIRM, S_WAIT, S_CP_RD, S_CP_EV,
        S_CLR, S_RSTAT, S_DONE
    } bp_state_e;

    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_BUF_SETUP   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_CLEAR       = 8'h50;

    localparam int ST_READY_BIT = 7;
    localparam int ST_LOCK_BIT  = 1;

    // saturating count of not-ready completion polls (0, 1, 2+)
    function automatic logic [1:0] sat_inc(input logic [1:0] v);
        return (v == 2'd3) ? v : v + 2'd1;
    endfunction

    function automatic logic powered(input bp_state_e s);
        case (s)
            S_SETUP, S_BR_RD, S_BR_EV, S_COUNT, S_DATA, S_CONFIRM,
            S_WAIT, S_CP_RD, S_CP_EV: return 1'b1;
            default:                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bprog_timer.sv
module bprog_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/bprog_waittune.sv
module bprog_waittune #(
    parameter int WAIT_W    = 8,
    parameter int WAIT_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [1:0]        busy_polls,
    output logic [WAIT_W-1:0] wait_val
);
    localparam logic [WAIT_W-1:0] W_MAX  = '1;
    localparam logic [WAIT_W-1:0] W_INIT = WAIT_W'(WAIT_INIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_val <= W_INIT;
        end else if (upd) begin
            if (busy_polls == 2'd0 && wait_val > WAIT_W'(1))
                wait_val <= wait_val - 1'b1;
            else if (busy_polls >= 2'd2 && wait_val != W_MAX)
                wait_val <= wait_val + 1'b1;
        end
    end
endmodule

// File: rtl/bprog_seq.sv
module bprog_seq
    import bprog_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int BUF_LOG2  = 4,
    parameter int BUF_POLLS = 20,
    parameter int READY_TO  = 64,
    parameter int WAIT_W    = 8,
    parameter int WAIT_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [BUF_LOG2:0] word_cnt,
    input  logic              in_query,
    input  logic [DW-1:0]     dat_word,
    output logic              dat_take,
    output logic [AW-1:0]     fl_addr,
    output logic [DW-1:0]     fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DW-1:0]     fl_rdata,
    output logic              vpp_en,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    localparam int CW     = BUF_LOG2 + 1;
    localparam int PW     = $clog2(BUF_POLLS + 1);
    localparam int TO_W   = $clog2(READY_TO + 1);
    localparam int TW     = (TO_W > WAIT_W) ? TO_W : WAIT_W;
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << BUF_LOG2) - 1);
    localparam logic [TW-1:0] T_READY  = TW'(READY_TO);
    localparam logic [TW-1:0] T_DONE   = TW'(READY_TO / 2);

    bp_state_e   st, nxt;
    bp_result_e  res_q, res_n;
    logic [AW-1:0] tgt_q, cmd_q;
    logic [CW-1:0] cnt_q, idx_q;
    logic [PW-1:0] bpolls_q;
    logic [1:0]    extra_q;

    logic          tmr_load, tmr_exp, upd;
    logic [TW-1:0] tmr_val;
    logic [WAIT_W-1:0] wait_val;
    logic          st_rdy, st_lock;
    logic          unused_rd;

    assign st_rdy    = fl_rdata[ST_READY_BIT];
    assign st_lock   = fl_rdata[ST_LOCK_BIT];
    assign unused_rd = ^{fl_rdata[DW-1:8], fl_rdata[6:2], fl_rdata[0]};

    bprog_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    bprog_waittune #(.WAIT_W(WAIT_W), .WAIT_INIT(WAIT_INIT)) u_tune (
        .clk(clk), .rst(rst), .upd(upd), .busy_polls(extra_q), .wait_val(wait_val)
    );

    function automatic logic [DW-1:0] op(input logic [7:0] c);
        return {{(DW-8){1'b0}}, c};
    endfunction

    always_comb begin
        nxt      = st;
        res_n    = res_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        upd      = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = cmd_q;
        fl_wdata = '0;
        dat_take = 1'b0;
        case (st)
            S_IDLE: if (start) begin
                nxt      = in_query ? S_QRY : S_PRE_RD;
                tmr_load = 1'b1;
                tmr_val  = T_READY;
            end
            S_QRY: begin
                fl_we = 1'b1; fl_wdata = op(OP_READ_STATUS); nxt = S_PRE_RD;
            end
            S_PRE_RD: begin fl_re = 1'b1; nxt = S_PRE_EV; end
            S_PRE_EV: begin
                if (st_rdy)        nxt = S_SETUP;
                else if (tmr_exp) begin nxt = S_DONE; res_n = RES_TIMEOUT; end
                else               nxt = S_PRE_RD;
            end
            S_SETUP: begin
                fl_we = 1'b1; fl_wdata = op(OP_BUF_SETUP); nxt = S_BR_RD;
            end
            S_BR_RD: begin fl_re = 1'b1; nxt = S_BR_EV; end
            S_BR_EV: begin
                if (st_rdy)                          nxt = S_COUNT;
                else if (bpolls_q == PW'(BUF_POLLS)) nxt = S_NR_EXIT;
                else                                 nxt = S_BR_RD;
            end
            S_NR_EXIT: begin
                fl_we = 1'b1; fl_wdata = op(OP_READ_STATUS);
                nxt = S_DONE; res_n = RES_NOT_READY;
            end
            S_COUNT: begin
                fl_we = 1'b1;
                fl_wdata = {{(DW-CW){1'b0}}, cnt_q - 1'b1};
                nxt = S_DATA;
            end
            S_DATA: begin
                fl_we    = 1'b1;
                dat_take = 1'b1;
                fl_addr  = tgt_q + {{(AW-CW){1'b0}}, idx_q};
                fl_wdata = dat_word;
                if (idx_q == cnt_q - 1'b1) nxt = S_CONFIRM;
            end
            S_CONFIRM: begin
                fl_we = 1'b1; fl_wdata = op(OP_CONFIRM);
                tmr_load = 1'b1;
                tmr_val  = {{(TW-WAIT_W){1'b0}}, wait_val} - 1'b1;
                nxt = S_WAIT;
            end
            S_WAIT: if (tmr_exp) begin
                tmr_load = 1'b1; tmr_val = T_DONE; nxt = S_CP_RD;
            end
            S_CP_RD: begin fl_re = 1'b1; nxt = S_CP_EV; end
            S_CP_EV: begin
                if (st_rdy) begin
                    upd = 1'b1;
                    if (st_lock) nxt = S_CLR;
                    else begin nxt = S_DONE; res_n = RES_OK; end
                end else if (tmr_exp) begin
                    nxt = S_DONE; res_n = RES_TIMEOUT;
                end else nxt = S_CP_RD;
            end
            S_CLR: begin
                fl_we = 1'b1; fl_wdata = op(OP_CLEAR); nxt = S_RSTAT;
            end
            S_RSTAT: begin
                fl_we = 1'b1; fl_wdata = op(OP_READ_STATUS);
                nxt = S_DONE; res_n = RES_LOCKED;
            end
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            res_q    <= RES_OK;
            tgt_q    <= '0;
            cmd_q    <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            bpolls_q <= '0;
            extra_q  <= '0;
        end else begin
            st    <= nxt;
            res_q <= res_n;
            case (st)
                S_IDLE: if (start) begin
                    tgt_q <= tgt_addr;
                    cmd_q <= tgt_addr & ~LOW_MASK;
                    cnt_q <= word_cnt;
                end
                S_SETUP:   bpolls_q <= '0;
                S_BR_RD:   bpolls_q <= bpolls_q + 1'b1;
                S_COUNT:   idx_q <= '0;
                S_DATA:    idx_q <= idx_q + 1'b1;
                S_WAIT:    extra_q <= '0;
                S_CP_EV:   if (!st_rdy) extra_q <= sat_inc(extra_q);
                default: ;
            endcase
        end
    end

    assign vpp_en = powered(st);
    assign busy   = (st != S_IDLE);
    assign done   = (st == S_DONE);
    assign result = res_q;
endmodule

// File: rtl/bprog_chk.sv
module bprog_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          vpp_en,
    input logic          fl_we,
    input logic          fl_re,
    input logic [DW-1:0] fl_wdata,
    input logic          dat_take
);
    localparam logic [DW-1:0] C_SETUP = DW'(8'hE8);
    localparam logic [DW-1:0] C_CLEAR = DW'(8'h50);
    localparam logic [DW-1:0] C_STAT  = DW'(8'h70);

    p_bus_excl_r14: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_re && !vpp_en));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_novpp_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !vpp_en);

    p_setup_vpp_r12: assert property (@(posedge clk) disable iff (rst)
        (fl_we && !dat_take && fl_wdata == C_SETUP) |-> vpp_en);

    p_clear_then_stat_r11: assert property (@(posedge clk) disable iff (rst)
        (fl_we && !vpp_en && fl_wdata == C_CLEAR) |=> (fl_we && fl_wdata == C_STAT));

    p_take_writes_r7: assert property (@(posedge clk) disable iff (rst)
        dat_take |-> (fl_we && vpp_en));
endmodule

bind bprog_seq bprog_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .vpp_en(vpp_en),
    .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata), .dat_take(dat_take)
);

// File: tb/sim_bprog_seq.sv
`timescale 1ns/1ps
module sim_bprog_seq;
    localparam int AW = 16, DW = 16, BL = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, in_query = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [BL:0]   word_cnt = '0;
    logic [DW-1:0] dat_word, fl_rdata = '0;
    logic dat_take, fl_we, fl_re, vpp_en, busy, done;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [1:0]    result;

    always #2.5 clk = ~clk;

    bprog_seq u0 (
        .clk(clk), .rst(rst), .start(start), .tgt_addr(tgt_addr), .word_cnt(word_cnt),
        .in_query(in_query), .dat_word(dat_word), .dat_take(dat_take),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .vpp_en(vpp_en), .busy(busy), .done(done), .result(result)
    );

    int errors = 0, checks = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scripted flash status model
    int phase, pre_n, buf_n, cp_n, dcount, take_idx, op_seed;
    int pre_busy, buf_busy, cp_busy, cur_cnt, d0_cyc, cp0_cyc, wn;
    bit lock, vpp_at_conf;
    logic [AW-1:0] wa [0:63];
    logic [DW-1:0] wd [0:63];

    assign dat_word = 16'h5A00 + 16'(op_seed * 32) + 16'(take_idx);

    always @(negedge clk) begin
        if (fl_we) begin
            if (wn < 64) begin wa[wn] = fl_addr; wd[wn] = fl_wdata; end
            wn = wn + 1;
            case (phase)
                0: if (fl_wdata == 16'h00E8) phase = 1;
                1: begin phase = 2; dcount = 0; end
                2: if (dcount == cur_cnt) begin
                       phase = 3; d0_cyc = cyc; vpp_at_conf = vpp_en;
                   end else dcount = dcount + 1;
                default: ;
            endcase
            if (dat_take) take_idx = take_idx + 1;
        end
        if (fl_re) begin
            case (phase)
                0: begin fl_rdata = (pre_n < pre_busy) ? 16'h0000 : 16'h0080; pre_n = pre_n + 1; end
                1: begin fl_rdata = (buf_n < buf_busy) ? 16'h0000 : 16'h0080; buf_n = buf_n + 1; end
                default: begin
                    if (cp_n == 0) cp0_cyc = cyc;
                    fl_rdata = (cp_n < cp_busy) ? 16'h0000 : (lock ? 16'h0082 : 16'h0080);
                    cp_n = cp_n + 1;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int w_exp = 4;   // adaptive wait tracked by the bench
    int got_res;

    task automatic run_op(input int tgt, input int cnt, input bit q,
                          input int pb, input int bb, input int cb, input bit lk);
        @(negedge clk);
        phase = 0; pre_n = 0; buf_n = 0; cp_n = 0; dcount = 0; take_idx = 0;
        pre_busy = pb; buf_busy = bb; cp_busy = cb; lock = lk; cur_cnt = cnt;
        d0_cyc = -1; cp0_cyc = -1; wn = 0; vpp_at_conf = 0; op_seed = op_seed + 1;
        tgt_addr = AW'(tgt); word_cnt = (BL+1)'(cnt); in_query = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_res = -1;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin got_res = int'(result); break; end
            @(negedge clk);
        end
        chk(got_res >= 0, "R13", "done seen", got_res, 0);
        chk(vpp_en == 1'b0, "R12", "vpp low at done", vpp_en, 0);
        @(negedge clk);
        chk(done == 1'b0, "R13", "done one cycle", done, 0);
        chk(busy == 1'b0, "R13", "idle after done", busy, 0);
    endtask

    task automatic chk_gap(input string tag);
        chk(cp0_cyc - d0_cyc == w_exp + 1, "R8", tag, cp0_cyc - d0_cyc, w_exp + 1);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !vpp_en && !fl_we && !fl_re, "R1", "reset outputs",
            {busy, done, vpp_en, fl_we, fl_re}, 0);
    endtask

    task automatic t_basic;
        run_op(16'h1234, 4, 0, 0, 0, 0, 0);
        chk(got_res == 0, "R11", "ok result", got_res, 0);
        chk(wn == 7, "R7", "write count", wn, 7);
        chk(wa[0] == 16'h1230 && wd[0] == 16'h00E8, "R5", "setup write", wd[0], 16'hE8);
        chk(wa[1] == 16'h1230 && wd[1] == 16'h0003, "R7", "count write", wd[1], 3);
        for (int i = 0; i < 4; i++) begin
            chk(wa[2+i] == 16'(16'h1234 + i), "R2", "data addr", wa[2+i], 16'h1234 + i);
            chk(wd[2+i] == 16'h5A00 + 16'(op_seed * 32) + 16'(i), "R7", "data word",
                wd[2+i], 16'h5A00 + op_seed * 32 + i);
        end
        chk(wa[6] == 16'h1230 && wd[6] == 16'h00D0, "R7", "confirm", wd[6], 16'hD0);
        chk(vpp_at_conf == 1'b1, "R12", "vpp at confirm", vpp_at_conf, 1);
        chk_gap("gap initial wait");
        w_exp = 3;
    endtask

    task automatic t_query;
        run_op(16'h0040, 1, 1, 0, 0, 0, 0);
        chk(wa[0] == 16'h0040 && wd[0] == 16'h0070, "R3", "status mode first", wd[0], 16'h70);
        chk(wd[1] == 16'h00E8 && wd[2] == 16'h0000, "R7", "setup then count 0", wd[2], 0);
        chk_gap("gap after decrement");
        w_exp = 2;
    endtask

    task automatic t_pre_wait;
        run_op(16'h2FFF, 2, 0, 3, 0, 1, 0);
        chk(pre_n == 4, "R4", "pre reads", pre_n, 4);
        chk(wa[0] == 16'h2FF0, "R2", "cmd alignment", wa[0], 16'h2FF0);
        chk(got_res == 0, "R4", "ok after pre wait", got_res, 0);
        chk_gap("gap before n=1");
    endtask

    task automatic t_pre_timeout;
        run_op(16'h0100, 2, 0, 100000, 0, 0, 0);
        chk(got_res == 1, "R4", "pre timeout result", got_res, 1);
        chk(wn == 0, "R4", "no writes", wn, 0);
    endtask

    task automatic t_buf_edge;
        run_op(16'h0300, 3, 0, 0, 19, 3, 0);
        chk(buf_n == 20, "R5", "ready on last poll", buf_n, 20);
        chk(got_res == 0, "R5", "ok result", got_res, 0);
        chk_gap("gap unchanged after n=1");
        w_exp = 3;
    endtask

    task automatic t_not_ready;
        run_op(16'h0400, 3, 0, 0, 100000, 0, 0);
        chk(buf_n == 20, "R6", "poll limit", buf_n, 20);
        chk(wn == 2 && wd[1] == 16'h0070, "R6", "status write", wd[1], 16'h70);
        chk(got_res == 2, "R6", "not ready result", got_res, 2);
    endtask

    task automatic t_cp_timeout;
        bit clr = 0;
        run_op(16'h0500, 2, 0, 0, 0, 100000, 0);
        chk(got_res == 1, "R10", "completion timeout", got_res, 1);
        for (int i = 0; i < wn && i < 64; i++) if (wd[i] == 16'h0050) clr = 1;
        chk(clr == 0, "R10", "no clear write", clr, 0);
        chk_gap("gap after incr and no-change endings");
    endtask

    task automatic t_lock;
        run_op(16'h0608, 2, 0, 0, 0, 0, 1);
        chk(got_res == 3, "R11", "protected result", got_res, 3);
        chk(wd[wn-2] == 16'h0050 && wd[wn-1] == 16'h0070 && wa[wn-1] == 16'h0600,
            "R11", "clear then status", wd[wn-2], 16'h50);
        chk_gap("gap after timeout");
        w_exp = 2;
    endtask

    task automatic t_floor;
        for (int k = 0; k < 3; k++) begin
            run_op(16'h0700, 1, 0, 0, 0, 0, 0);
            chk_gap("R9 floor gap");
            if (w_exp > 1) w_exp = w_exp - 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        op_seed = 0; wn = 0; phase = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_basic();
        t_query();
        t_pre_wait();
        t_pre_timeout();
        t_buf_edge();
        t_not_ready();
        t_cp_timeout();
        t_lock();
        t_floor();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule